// File: doc/BRIEF.md
# Edge-Selected Timer Capture Channel

This block is one capture lane of a timer. It watches one of four sources: two external pins, a constant low level and a constant high level. When the chosen kind of transition shows up on that source, it copies the timer's current count into a holding register. The timer's count is supplied from outside; the counter itself lives elsewhere. Each capture raises a pending flag. When the interrupt enable is set, the pending flag drives an interrupt request. If a capture lands while the previous one is still pending, a sticky overflow flag records that a value was lost.

Software can make a capture happen without touching the pins. It does this by switching the source select between a pin and one of the constant levels. An optional chain of resynchronising flops moves a pin that is asynchronous into the timer clock domain before the edge detector sees it.

The captured value flows out with no handshake and cannot be back-pressured. The pending flag acts as its valid indication. Software acknowledges a value by pulsing the pending clear. A capture that arrives before that acknowledgement overwrites the held value and is reported through the overflow flag instead of being stalled.

Top module: `cap_channel`

## Requirements
- R1: On a qualifying edge the channel loads `cap_value` with the `count` present at the capturing clock edge and sets `pend`.
- R2: `edge_mode` selects the qualifying edges: 2'b00 none, 2'b01 rising (0 to 1), 2'b10 falling (1 to 0), 2'b11 either direction.
- R3: `in_sel` picks the source: 2'b00 `pin_a`, 2'b01 `pin_b`, 2'b10 constant 0, 2'b11 constant 1. A change of `in_sel` that changes the selected level is an edge like any other.
- R4: With `cap_mode` = 0 (compare operation) no capture happens: `cap_value` and `pend` are unchanged by any edge.
- R5: `in_level` always shows the level of the currently selected source, without a clock delay.
- R6: A capture occurring while `pend` is 1 sets `ovf`. A capture while `pend` is 0 leaves `ovf` unchanged.
- R7: `ovf` stays 1 until a cycle with `clr_ovf` = 1 and no overflowing capture. If the clear and an overflowing capture share a cycle, `ovf` stays 1.
- R8: `clr_pend` = 1 clears `pend` at the next clock edge. If a capture happens on the same edge, `pend` stays 1.
- R9: `irq` is 1 exactly when `pend` and `irq_en` are both 1, and follows `irq_en` without a clock delay.
- R10: With `sync_en` = 0 a source change is captured at the first clock edge after it. With `sync_en` = 1 it is captured at the (SYNC_STAGES+1)th edge, third with the default of 2.
- R11: While `rst_n` is 0: `cap_value` is 0, `pend` is 0, `ovf` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count | input | CNT_W | Current timer count |
| pin_a | input | 1 | External source A |
| pin_b | input | 1 | External source B |
| in_sel | input | 2 | Source select |
| edge_mode | input | 2 | Qualifying-edge select |
| sync_en | input | 1 | 1 = route source through synchroniser |
| cap_mode | input | 1 | 1 = capture operation, 0 = compare operation |
| irq_en | input | 1 | Interrupt enable |
| clr_pend | input | 1 | Pending-flag clear strobe |
| clr_ovf | input | 1 | Overflow-flag clear strobe |
| cap_value | output | CNT_W | Captured count |
| in_level | output | 1 | Level of the selected source |
| pend | output | 1 | Capture pending |
| ovf | output | 1 | Capture overflow (sticky) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume two things about the inputs. First, a clear strobe is sampled only at clock edges. Second, with `sync_en` low, the selected pin is already settled at the clock edge, so the stored source history always holds a defined level. The stimulus drives every input, including the pins and `in_sel`, at the falling clock edge and holds it for at least a full cycle. It also lets the source history settle for several cycles before each trial clears the flags and applies a single edge. Only the overflow sequence deliberately issues a capture and a clear on the same edge, to exercise the set-wins priority.

// File: rtl/cap_pkg.sv
`timescale 1ns/1ps
package cap_pkg;
  typedef enum logic [1:0] {
    SRC_PIN_A = 2'b00,
    SRC_PIN_B = 2'b01,
    SRC_LOW   = 2'b10,
    SRC_HIGH  = 2'b11
  } src_sel_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/cap_src_select.sv
`timescale 1ns/1ps
// Four-way source selection plus an optional resynchronising chain.
module cap_src_select #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_a,
  input  logic       pin_b,
  input  logic [1:0] sel,
  input  logic       sync_en,
  output logic       level,
  output logic       sampled
);
  import cap_pkg::*;

  logic [STAGES-1:0] chain;

  always_comb begin
    case (src_sel_e'(sel))
      SRC_PIN_A: level = pin_a;
      SRC_PIN_B: level = pin_b;
      SRC_LOW:   level = 1'b0;
      default:   level = 1'b1;
    endcase
  end

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= level;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign sampled = sync_en ? chain[STAGES-1] : level;
endmodule

// File: rtl/cap_edge_qual.sv
`timescale 1ns/1ps
// Compares the present sample with the previous one and qualifies the edge.
module cap_edge_qual (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sampled,
  input  logic [1:0] edge_mode,
  input  logic       cap_mode,
  output logic       hit
);
  import cap_pkg::*;

  logic prev;
  logic rise;
  logic fall;
  logic match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= sampled;
  end

  assign rise = sampled & ~prev;
  assign fall = ~sampled & prev;

  always_comb begin
    case (edge_mode_e'(edge_mode))
      EDGE_RISE: match = rise;
      EDGE_FALL: match = fall;
      EDGE_ANY:  match = rise | fall;
      default:   match = 1'b0;
    endcase
  end

  assign hit = cap_mode & match;
endmodule

// File: rtl/cap_event_flags.sv
`timescale 1ns/1ps
// Holding register and the pending / overflow flags.
module cap_event_flags #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [CNT_W-1:0] count,
  input  logic             clr_pend,
  input  logic             clr_ovf,
  output logic [CNT_W-1:0] cap_value,
  output logic             pend,
  output logic             ovf
);
  logic lost;

  assign lost = hit & pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_value <= '0;
      pend      <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      if (hit) cap_value <= count;
      pend <= hit  | (pend & ~clr_pend);
      ovf  <= lost | (ovf  & ~clr_ovf);
    end
  end
endmodule

// File: rtl/cap_channel.sv
`timescale 1ns/1ps
// One timer capture channel: source select, edge qualify, capture flags.
module cap_channel #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             pin_a,
  input  logic             pin_b,
  input  logic [1:0]       in_sel,
  input  logic [1:0]       edge_mode,
  input  logic             sync_en,
  input  logic             cap_mode,
  input  logic             irq_en,
  input  logic             clr_pend,
  input  logic             clr_ovf,
  output logic [CNT_W-1:0] cap_value,
  output logic             in_level,
  output logic             pend,
  output logic             ovf,
  output logic             irq
);
  logic sampled;
  logic hit;

  cap_src_select #(.STAGES(SYNC_STAGES)) u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_a   (pin_a),
    .pin_b   (pin_b),
    .sel     (in_sel),
    .sync_en (sync_en),
    .level   (in_level),
    .sampled (sampled)
  );

  cap_edge_qual u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .sampled   (sampled),
    .edge_mode (edge_mode),
    .cap_mode  (cap_mode),
    .hit       (hit)
  );

  cap_event_flags #(.CNT_W(CNT_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .count     (count),
    .clr_pend  (clr_pend),
    .clr_ovf   (clr_ovf),
    .cap_value (cap_value),
    .pend      (pend),
    .ovf       (ovf)
  );

  assign irq = pend & irq_en;
endmodule

// File: rtl/cap_channel_chk.sv
`timescale 1ns/1ps
module cap_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       in_sel,
  input logic             cap_mode,
  input logic             irq_en,
  input logic             clr_pend,
  input logic             clr_ovf,
  input logic [CNT_W-1:0] cap_value,
  input logic             in_level,
  input logic             pend,
  input logic             ovf,
  input logic             irq
);
  AST_VALUE_WITH_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_value) |-> pend); // R1

  AST_LOW_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sel == 2'b10) |-> !in_level); // R3

  AST_HIGH_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sel == 2'b11) |-> in_level); // R3

  AST_COMPARE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_mode |=> $stable(cap_value)); // R4

  AST_OVF_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(pend)); // R6

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr_ovf) |=> ovf); // R7

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr_pend) |=> pend); // R8

  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && pend)); // R9
endmodule

bind cap_channel cap_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_sel    (in_sel),
  .cap_mode  (cap_mode),
  .irq_en    (irq_en),
  .clr_pend  (clr_pend),
  .clr_ovf   (clr_ovf),
  .cap_value (cap_value),
  .in_level  (in_level),
  .pend      (pend),
  .ovf       (ovf),
  .irq       (irq)
);

// File: tb/sim_cap_channel.sv
`timescale 1ns/1ps
module sim_cap_channel;
  localparam int W   = 16;
  localparam int STG = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] count;
  logic         pin_a, pin_b, sync_en, cap_mode, irq_en, clr_pend, clr_ovf;
  logic [1:0]   in_sel, edge_mode;
  logic [W-1:0] cap_value;
  logic         in_level, pend, ovf, irq;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cap_channel #(.CNT_W(W), .SYNC_STAGES(STG)) u0 (
    .clk(clk), .rst_n(rst_n), .count(count), .pin_a(pin_a), .pin_b(pin_b),
    .in_sel(in_sel), .edge_mode(edge_mode), .sync_en(sync_en),
    .cap_mode(cap_mode), .irq_en(irq_en), .clr_pend(clr_pend),
    .clr_ovf(clr_ovf), .cap_value(cap_value), .in_level(in_level),
    .pend(pend), .ovf(ovf), .irq(irq)
  );

  function automatic logic [W-1:0] cval(int c);
    logic [31:0] t;
    t = c * 37 + 11;
    return t[W-1:0];
  endfunction

  task automatic step();
    @(negedge clk);
    cyc++;
    count = cval(cyc);
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_flags();
    clr_pend = 1'b1;
    clr_ovf  = 1'b1;
    step();
    clr_pend = 1'b0;
    clr_ovf  = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; count = '0; pin_a = 0; pin_b = 0; in_sel = 2'b00;
    edge_mode = 2'b00; sync_en = 0; cap_mode = 0; irq_en = 1;
    clr_pend = 0; clr_ovf = 0;
    repeat (3) step();
    chk("R11 cap_value", int'(cap_value), 0);
    chk("R11 pend", int'(pend), 0);
    chk("R11 ovf", int'(ovf), 0);
    chk("R11 irq", int'(irq), 0);
    rst_n = 1'b1;
    repeat (3) step();

    // Sweep: sync x mode bit x edge mode x source x direction
    for (int sy = 0; sy < 2; sy++)
      for (int cm = 0; cm < 2; cm++)
        for (int md = 0; md < 4; md++)
          for (int src = 0; src < 4; src++)
            for (int dir = 0; dir < 2; dir++) begin
              logic [W-1:0] old;
              logic         rising, exp_hit;
              int           c0;
              if (src >= 2 && dir == 1) continue;
              rising   = (src == 2) || (src < 2 && dir == 0);
              sync_en  = sy[0];
              cap_mode = cm[0];
              edge_mode = md[1:0];
              irq_en   = ((md + src) % 2) == 0;
              pin_a = 0; pin_b = 0;
              if (src < 2) begin
                in_sel = src[1:0];
                if (src == 0) pin_a = dir[0]; else pin_b = dir[0];
              end else begin
                in_sel = 2'b00;
                pin_a  = (src == 3);
              end
              repeat (5) step();
              clear_flags();
              old = cap_value;
              step();
              c0 = cyc;
              case (src)
                0: pin_a  = ~pin_a;
                1: pin_b  = ~pin_b;
                2: in_sel = 2'b11;
                default: in_sel = 2'b10;
              endcase
              exp_hit = cm[0] && (md == 3 || (md == 1 && rising) || (md == 2 && !rising));
              #1;
              chk(src >= 2 ? "R3 in_level const" : "R5 in_level", int'(in_level), int'(rising));
              repeat (STG) step();
              chk("R10 latency pend", int'(pend), (sy == 0) ? int'(exp_hit) : 0);
              step();
              if (exp_hit) begin
                chk("R1 R2 R10 cap_value", int'(cap_value), int'(cval(sy ? c0 + STG : c0)));
                chk("R1 pend", int'(pend), 1);
                chk("R9 irq", int'(irq), int'(irq_en));
              end else begin
                chk(cm ? "R2 no capture value" : "R4 compare value", int'(cap_value), int'(old));
                chk(cm ? "R2 no capture pend" : "R4 compare pend", int'(pend), 0);
                chk("R9 irq idle", int'(irq), 0);
              end
              chk("R6 single capture no ovf", int'(ovf), 0);
            end

    // Overflow and clear priority sequence
    begin
      int c1;
      sync_en = 0; cap_mode = 1; edge_mode = 2'b11; in_sel = 2'b00;
      pin_a = 0; irq_en = 0;
      repeat (4) step();
      clear_flags();
      pin_a = 1;
      step();
      chk("R6 first capture pend", int'(pend), 1);
      chk("R6 first capture ovf", int'(ovf), 0);
      chk("R9 masked irq", int'(irq), 0);
      irq_en = 1;
      #1;
      chk("R9 irq follows enable", int'(irq), 1);
      c1 = cyc;
      pin_a = 0;
      step();
      chk("R6 second capture ovf", int'(ovf), 1);
      chk("R1 overwrite value", int'(cap_value), int'(cval(c1)));
      clr_pend = 1;
      step();
      clr_pend = 0;
      chk("R8 clear pend", int'(pend), 0);
      chk("R7 ovf survives pend clear", int'(ovf), 1);
      step();
      chk("R7 ovf sticky", int'(ovf), 1);
      pin_a = 1; clr_pend = 1;
      step();
      clr_pend = 0;
      chk("R8 capture beats clear", int'(pend), 1);
      pin_a = 0; clr_ovf = 1;
      step();
      clr_ovf = 0;
      chk("R7 overflow beats clear", int'(ovf), 1);
      clr_ovf = 1;
      step();
      clr_ovf = 0;
      chk("R7 ovf cleared", int'(ovf), 0);
      chk("R7 pend kept", int'(pend), 1);
      clr_pend = 1;
      step();
      clr_pend = 0;
      chk("R8 pend cleared", int'(pend), 0);
      chk("R9 irq drops", int'(irq), 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule